// File: doc/BRIEF.md
# Multi-Mode Parallel Port FIFO

This block is the byte queue behind the single data offset of a multi-mode parallel port. The host reaches it through a write strobe and a read strobe. The peripheral-side handshake engine reaches it through a pop port and a push port. A 3-bit mode input and a direction bit decide which side fills the queue and which side drains it.

There are three queue-using modes.
- Mode 3'b010 is the compatible forward path: the host fills and the handshake engine drains.
- Mode 3'b011 is the extended-capability path. It drains to the peripheral when the direction bit is 0 and fills from the peripheral when it is 1.
- Mode 3'b110 is a loopback test path: the host both fills and drains, and the peripheral ports are ignored.

In the test path a write to a full queue is dropped, and a read of an empty queue presents the last byte read again. Neither case stalls. Any other mode value parks the queue.

A controller state machine is registered from the mode and direction inputs. Its states are:
- ST_IDLE: no queue mode.
- ST_COMPAT: mode 010.
- ST_ECP_OUT and ST_ECP_IN: mode 011 with direction 0 or 1.
- ST_TEST_OUT and ST_TEST_IN: mode 110 with direction 0 or 1.

Every cycle the state moves to the state that the current mode and direction select. The transitions are:
- mode change: the cycle where mode differs from its registered copy flushes the queue and performs no access.
- direction change: ECP_OUT to ECP_IN, TEST_OUT to TEST_IN and back. This takes effect one cycle later without a flush.
- hold: the inputs are unchanged.

A host read updates the read-data register on the clock edge that samples the strobe. The head byte on the peripheral side is combinational.

Top module: `ppf_fifo`

## Requirements
- R1: In mode 010, host writes enter the queue and peripheral pops return them in order on per_rdata. Host reads do nothing: host_rdata and occupancy stay unchanged.
- R2: In mode 011 with direction 0, host writes are drained in order by peripheral pops, and peripheral pushes are ignored.
- R3: In mode 011 with direction 1, peripheral pushes are returned in order by host reads, and host writes are ignored.
- R4: In mode 110, host writes and host reads pass bytes through the queue in order, and peripheral pops and pushes leave the contents unchanged.
- R5: A write that arrives while the queue holds 16 bytes is dropped, and the 16 stored bytes read back unchanged.
- R6: A host read of an empty queue in mode 110 leaves host_rdata at the last byte read and leaves the queue empty.
- R7: full is 1 exactly when 16 bytes are held, and empty is 1 exactly when none are held, including after dropped writes and repeated reads.
- R8: service_intr is 1 when 8 or more entries are free in mode 010 and in direction 0 of modes 011 and 110. It is 1 when 8 or more entries are filled in direction 1 of those modes. In every other mode it is 0.
- R9: A mode change empties the queue, sets host_rdata to 0x00, and ignores all strobes in that cycle.
- R10: In modes other than 010, 011 and 110, every strobe is ignored and the queue stays empty.
- R11: A fill and a drain in the same cycle both act, each judged on the flags held before the edge: when full, the drain happens and the fill is dropped; when empty, the fill happens and the read repeats the last byte.
- R12: After reset, empty is 1, full is 0, service_intr is 0 and host_rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Port mode: 010 compatible, 011 extended, 110 test |
| dir | input | 1 | 0 = toward peripheral, 1 = toward host |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Last byte read by the host |
| per_pop | input | 1 | Handshake engine takes the head byte |
| per_rdata | output | 8 | Head byte offered to the handshake engine |
| per_push | input | 1 | Handshake engine delivers a byte |
| per_wdata | input | 8 | Byte from the handshake engine |
| full | output | 1 | Queue holds 16 bytes |
| empty | output | 1 | Queue holds no bytes |
| service_intr | output | 1 | Threshold service request |

## Verification
Filling and draining can land in the same cycle: a host write with a peripheral pop in mode 010, and a host write with a host read in mode 110. The bench drives both strobes in one cycle in three situations: a one-byte queue, a full queue and an empty queue. A scoreboard queue judges the result. The dropped fill must never show up later in the drained sequence, and a read of the empty queue must present the previous byte rather than the byte written in that cycle.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

    localparam logic [2:0] MODE_COMPAT = 3'b010;
    localparam logic [2:0] MODE_ECP    = 3'b011;
    localparam logic [2:0] MODE_TEST   = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_COMPAT   = 3'd1,
        ST_ECP_OUT  = 3'd2,
        ST_ECP_IN   = 3'd3,
        ST_TEST_OUT = 3'd4,
        ST_TEST_IN  = 3'd5
    } ppf_state_e;

endpackage

// File: rtl/ppf_mem.sv
module ppf_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/ppf_ptrs.sv
module ppf_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wptr <= wptr + 1'b1;
            end
            if (pop) begin
                rptr <= rptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));

    assert_count_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |=> (count == CW'($past(count) + 1'b1)));

    assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush) |=> $stable(count));

    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/ppf_ctrl.sv
module ppf_ctrl
    import ppf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int THRESH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              dir,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              per_pop,
    input  logic              per_push,
    input  logic              full,
    input  logic              empty,
    input  logic [CW-1:0]     count,
    input  logic [DATA_W-1:0] head,
    output logic              flush,
    output logic              push,
    output logic              pop,
    output logic              push_sel,
    output logic [DATA_W-1:0] host_rdata,
    output logic              service_intr
);

    localparam logic [CW-1:0] LO_MARK = CW'(DEPTH - THRESH);
    localparam logic [CW-1:0] HI_MARK = CW'(THRESH);

    ppf_state_e state, nxt;
    logic [2:0] mode_q;
    logic       host_pop;

    // Next state follows the mode and direction inputs
    always_comb begin
        unique case (mode)
            MODE_COMPAT: nxt = ST_COMPAT;
            MODE_ECP:    nxt = dir ? ST_ECP_IN : ST_ECP_OUT;
            MODE_TEST:   nxt = dir ? ST_TEST_IN : ST_TEST_OUT;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= 3'b000;
        end else begin
            state  <= nxt;
            mode_q <= mode;
        end
    end

    assign flush = (mode != mode_q);

    // Per-state permissions and threshold flag
    always_comb begin
        push         = 1'b0;
        pop          = 1'b0;
        push_sel     = 1'b0;
        host_pop     = 1'b0;
        service_intr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                service_intr = 1'b0;
            end
            ST_COMPAT, ST_ECP_OUT: begin
                push         = host_wr && !full && !flush;
                pop          = per_pop && !empty && !flush;
                service_intr = (count <= LO_MARK);
            end
            ST_ECP_IN: begin
                push_sel     = 1'b1;
                push         = per_push && !full && !flush;
                pop          = host_rd && !empty && !flush;
                host_pop     = pop;
                service_intr = (count >= HI_MARK);
            end
            ST_TEST_OUT: begin
                push         = host_wr && !full && !flush;
                pop          = host_rd && !empty && !flush;
                host_pop     = pop;
                service_intr = (count <= LO_MARK);
            end
            ST_TEST_IN: begin
                push         = host_wr && !full && !flush;
                pop          = host_rd && !empty && !flush;
                host_pop     = pop;
                service_intr = (count >= HI_MARK);
            end
            default: begin
                service_intr = 1'b0;
            end
        endcase
    end

    // Last byte read by the host; an empty read leaves it in place
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (flush) begin
            host_rdata <= '0;
        end else if (host_pop) begin
            host_rdata <= head;
        end
    end

    assert_empty_reread_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TEST_OUT || state == ST_TEST_IN) && host_rd && empty && !flush)
        |=> $stable(host_rdata));

    assert_compat_rd_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMPAT && !flush) |=> $stable(host_rdata));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (host_rdata == '0));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!push && !pop));

endmodule

// File: rtl/ppf_fifo.sv
module ppf_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int THRESH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              dir,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              per_pop,
    output logic [DATA_W-1:0] per_rdata,
    input  logic              per_push,
    input  logic [DATA_W-1:0] per_wdata,
    output logic              full,
    output logic              empty,
    output logic              service_intr
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic              flush;
    logic              push;
    logic              pop;
    logic              push_sel;
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;
    logic [CW-1:0]     count;
    logic [DATA_W-1:0] head;
    logic [DATA_W-1:0] fill_data;

    assign fill_data = push_sel ? per_wdata : host_wdata;
    assign per_rdata = head;

    ppf_ctrl #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .THRESH (THRESH)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .dir          (dir),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .per_pop      (per_pop),
        .per_push     (per_push),
        .full         (full),
        .empty        (empty),
        .count        (count),
        .head         (head),
        .flush        (flush),
        .push         (push),
        .pop          (pop),
        .push_sel     (push_sel),
        .host_rdata   (host_rdata),
        .service_intr (service_intr)
    );

    ppf_ptrs #(
        .DEPTH (DEPTH)
    ) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .pop   (pop),
        .wptr  (wptr),
        .rptr  (rptr),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    ppf_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_mem (
        .clk   (clk),
        .we    (push),
        .waddr (wptr),
        .wdata (fill_data),
        .raddr (rptr),
        .rdata (head)
    );

    assert_full_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

// File: tb/ppf_fifo_bench.sv
`timescale 1ns/1ps
module ppf_fifo_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'b000;
    logic       dir = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       per_pop = 1'b0;
    logic [7:0] per_rdata;
    logic       per_push = 1'b0;
    logic [7:0] per_wdata = 8'h00;
    logic       full;
    logic       empty;
    logic       service_intr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    logic [7:0] last_exp = 8'h00;
    int         rd_kind = 0;     // 0 none, 1 pop expected, 2 hold expected
    bit         pop_chk = 0;
    string      cur_req = "R0";

    int         mon_rd_kind = 0;
    bit         mon_pop = 0;
    logic [7:0] mon_pdata = 8'h00;
    string      mon_req = "R0";

    always #2.5 clk = ~clk;

    ppf_fifo u_ppf_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .dir          (dir),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_rd      (host_rd),
        .host_rdata   (host_rdata),
        .per_pop      (per_pop),
        .per_rdata    (per_rdata),
        .per_push     (per_push),
        .per_wdata    (per_wdata),
        .full         (full),
        .empty        (empty),
        .service_intr (service_intr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: capture events at the edge, judge them at the falling edge
    always @(posedge clk) begin
        mon_rd_kind <= host_rd ? rd_kind : 0;
        mon_pop     <= per_pop && pop_chk;
        mon_pdata   <= per_rdata;
        mon_req     <= cur_req;
    end

    always @(negedge clk) begin
        logic [7:0] e;
        if (mon_rd_kind == 1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, mon_req, host_rdata, 8'hxx);
            end else begin
                e = exp_q.pop_front();
                check(host_rdata == e, mon_req, host_rdata, e);
                last_exp = e;
            end
        end else if (mon_rd_kind == 2) begin
            check(host_rdata == last_exp, mon_req, host_rdata, last_exp);
        end
        if (mon_pop) begin
            if (exp_q.size() == 0) begin
                check(1'b0, mon_req, mon_pdata, 8'hxx);
            end else begin
                e = exp_q.pop_front();
                check(mon_pdata == e, mon_req, mon_pdata, e);
            end
        end
    end

    task automatic cyc(input bit wr, input logic [7:0] wd, input int rk,
                       input bit pp, input bit pchk, input bit pu, input logic [7:0] pd);
        @(negedge clk);
        #1;
        host_wr    = wr;
        host_wdata = wd;
        host_rd    = (rk != 0);
        rd_kind    = rk;
        per_pop    = pp;
        pop_chk    = pchk;
        per_push   = pu;
        per_wdata  = pd;
    endtask

    task automatic idle();
        cyc(0, 8'h00, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic hw(input logic [7:0] b, input bit acc);
        if (acc) exp_q.push_back(b);
        cyc(1, b, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic hr(input int kind);
        cyc(0, 8'h00, kind, 0, 0, 0, 8'h00);
    endtask

    task automatic ppush(input logic [7:0] b, input bit acc);
        if (acc) exp_q.push_back(b);
        cyc(0, 8'h00, 0, 0, 0, 1, b);
    endtask

    task automatic ppop(input bit chk);
        cyc(0, 8'h00, 0, 1, chk, 0, 8'h00);
    endtask

    task automatic set_mode(input logic [2:0] m, input bit d);
        @(negedge clk);
        #1;
        mode = m;
        dir  = d;
        exp_q.delete();
        last_exp = 8'h00;
        idle();
        idle();
    endtask

    task automatic set_dir(input bit d);
        @(negedge clk);
        #1;
        dir = d;
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all) actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        idle();
        // R12 reset state
        cur_req = "R12";
        check(empty == 1'b1, "R12 empty", empty, 1);
        check(full == 1'b0, "R12 full", full, 0);
        check(service_intr == 1'b0, "R12 service_intr", service_intr, 0);
        check(host_rdata == 8'h00, "R12 host_rdata", host_rdata, 0);

        // R10 parked mode ignores all strobes
        cur_req = "R10";
        hw(8'h11, 0);
        ppush(8'h12, 0);
        hr(2);
        idle();
        check(empty == 1'b1, "R10 empty", empty, 1);
        check(service_intr == 1'b0, "R10 service_intr R8", service_intr, 0);

        // R1 compatible forward path
        set_mode(3'b010, 1);
        cur_req = "R1";
        hw(8'hA0, 1);
        hw(8'hA1, 1);
        hw(8'hA2, 1);
        idle();
        check(service_intr == 1'b1, "R8 compat free>=8", service_intr, 1);
        hr(2);
        idle();
        check(!empty, "R1 read ignored", empty, 0);
        ppop(1);
        ppop(1);
        ppop(1);
        idle();
        check(empty == 1'b1, "R1 drained", empty, 1);
        // R11 fill and drain together with one byte held
        cur_req = "R11";
        hw(8'hB1, 1);
        exp_q.push_back(8'hB2);
        cyc(1, 8'hB2, 0, 1, 1, 0, 8'h00);
        ppop(1);
        idle();
        check(empty == 1'b1, "R11 compat drained", empty, 1);

        // R2 extended path toward peripheral
        set_mode(3'b011, 0);
        cur_req = "R2";
        hw(8'hC0, 1);
        ppush(8'hCC, 0);
        hw(8'hC1, 1);
        ppop(1);
        ppop(1);
        idle();
        check(empty == 1'b1, "R2 push ignored", empty, 1);

        // R3 extended path toward host
        set_dir(1);
        idle();
        check(empty == 1'b1, "R3 dir switch keeps queue", empty, 1);
        cur_req = "R3";
        for (int i = 0; i < 7; i++) ppush(8'hD0 + 8'(i), 1);
        hw(8'hEE, 0);
        idle();
        check(service_intr == 1'b0, "R8 in 7 filled", service_intr, 0);
        ppush(8'hD7, 1);
        idle();
        check(service_intr == 1'b1, "R8 in 8 filled", service_intr, 1);
        for (int i = 0; i < 8; i++) hr(1);
        idle();
        check(empty == 1'b1, "R3 drained", empty, 1);
        ppush(8'h3C, 1);
        idle();

        // R9 mode change flushes
        set_mode(3'b110, 0);
        cur_req = "R9";
        check(empty == 1'b1, "R9 empty", empty, 1);
        check(host_rdata == 8'h00, "R9 host_rdata", host_rdata, 0);

        // R5 R7 R8 test path fill, overflow, threshold
        cur_req = "R5";
        for (int i = 0; i < 16; i++) hw(8'h40 + 8'(i), 1);
        idle();
        check(full == 1'b1, "R7 full at 16", full, 1);
        check(service_intr == 1'b0, "R8 out none free", service_intr, 0);
        hw(8'hEE, 0);
        idle();
        check(full == 1'b1, "R7 full after drop", full, 1);
        for (int i = 0; i < 7; i++) hr(1);
        idle();
        check(service_intr == 1'b0, "R8 out 7 free", service_intr, 0);
        hr(1);
        idle();
        check(service_intr == 1'b1, "R8 out 8 free", service_intr, 1);
        for (int i = 0; i < 8; i++) hr(1);
        idle();
        check(empty == 1'b1, "R7 empty at 0", empty, 1);

        // R6 empty read repeats last byte
        cur_req = "R6";
        hr(2);
        hr(2);
        idle();
        check(empty == 1'b1, "R6 still empty", empty, 1);
        check(host_rdata == 8'h4F, "R6 repeat value", host_rdata, 8'h4F);

        // R4 peripheral strobes ignored in test path
        cur_req = "R4";
        hw(8'h77, 1);
        ppop(0);
        ppush(8'h99, 0);
        idle();
        check(empty == 1'b0, "R4 after periph pop", empty, 0);
        hr(1);
        idle();
        check(empty == 1'b1, "R4 periph push ignored", empty, 1);

        // R11 full and empty concurrent cases
        cur_req = "R11";
        for (int i = 0; i < 16; i++) hw(8'h80 + 8'(i), 1);
        cyc(1, 8'hDD, 1, 0, 0, 0, 8'h00);
        idle();
        check(full == 1'b0, "R11 full drop", full, 0);
        for (int i = 0; i < 15; i++) hr(1);
        idle();
        check(empty == 1'b1, "R11 drained", empty, 1);
        exp_q.push_back(8'h5A);
        cyc(1, 8'h5A, 2, 0, 0, 0, 8'h00);
        idle();
        check(empty == 1'b0, "R11 empty fill", empty, 0);
        hr(1);
        idle();

        // R8 direction 1 in test path
        set_dir(1);
        cur_req = "R8";
        for (int i = 0; i < 8; i++) hw(8'h20 + 8'(i), 1);
        idle();
        check(service_intr == 1'b1, "R8 test in 8 filled", service_intr, 1);
        hr(1);
        idle();
        check(service_intr == 1'b0, "R8 test in 7 filled", service_intr, 0);
        for (int i = 0; i < 7; i++) hr(1);
        idle();
        idle();
        check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule